// File: doc/BRIEF.md
# Scan Test Time Calculator

This engine works out how many test clock cycles a flat scan network needs to run the tests of all of its instruments. The network is a single chain of N one-bit segment selectors, and each selector gates one scan-chain instrument. Software, or a test controller, first writes each instrument's chain length and pattern count into a small register file. It then pulses `start` and chooses either concurrent or sequential scheduling.

The engine replays the schedule one scan sequence at a time and visits one selector per clock. Every sequence pays one bit for each selector, the chain length of each selector that is open, and a fixed five-cycle capture-and-update overhead. A leading setup sequence shifts only the N selector bits.

When the replay is complete, the engine pulses `done` for one cycle. It then holds three results until the next run starts:
- the total cycle count;
- the cycles spent shifting selector bits;
- the cycles spent in capture-and-update.

Top module: `scan_time_calc`

## Requirements
- R1: Every run begins with a setup sequence worth N + 5 cycles. That sequence adds N to the selector count and 5 to the capture-and-update count.
- R2: With `seq_mode`=0 (concurrent), all instruments are open from the first scan sequence. Each sequence costs N + 5 plus the length L of every instrument that is still open. For L = 3,5,4 and P = 5,4,10 the total is 183.
- R3: An instrument is open for exactly P+1 scan sequences. The run lasts max(P+1) sequences in concurrent mode and the sum of (P+1) in sequential mode. `busy` stays high for N clocks per sequence, starting the clock after `start` is accepted.
- R4: With `seq_mode`=1 (sequential), instruments are tested one after another in index order. Each instrument costs (L + N + 5)·(P+1) cycles after the setup sequence. For the R2 values the total is 271.
- R5: With S scan sequences in a run, the selector overhead output equals N·(S+1) and the capture-and-update output equals 5·(S+1). For the R2 values in concurrent mode these are 36 and 60.
- R6: `done` is high for exactly one clock, the clock after the last selector of the last sequence, and `busy` is low at that point. All three results stay unchanged while the engine is idle and no start arrives.
- R7: Each result counter saturates at 2^CNT_W − 1 and never wraps.
- R8: A `start` pulse while `busy` is high is ignored. The run in progress keeps its mode, length and results.
- R9: Register-file writes (`cfg_we` with index, length and pattern count) take effect only while idle. Writes issued while busy are dropped and do not change later runs.
- R10: After reset, `busy` and `done` are low and all three results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register-file write strobe |
| cfg_idx | input | IDX_W | Instrument index to write |
| cfg_len | input | LEN_W | Scan-chain length L |
| cfg_pat | input | PAT_W | Pattern count P |
| start | input | 1 | Start pulse, accepted only when idle |
| seq_mode | input | 1 | 0 = concurrent, 1 = sequential, latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle result-valid pulse |
| total_cycles | output | CNT_W | Total test time in cycles |
| sib_cycles | output | CNT_W | Cycles spent shifting selector bits |
| cuc_cycles | output | CNT_W | Cycles spent in capture-and-update |

## Verification
The bench targets the following failure modes:
- Off-by-one sequence counts. An engine that closes a selector after P sequences instead of P+1 would fall short of 183 and 271, and its `busy` window would be one sequence shorter per instrument.
- A sequential walk that leaves later instruments open, or lets the cursor advance early. Either would mix chain lengths into the wrong sequences and miss the closed-form totals.
- Edge cases: single-pattern instruments with P = 0, and counters driven past 2^16. A wrapping adder would report a small total where the model expects the ceiling value.
- Control misuse: start pulses and register writes issued mid-run. A design that honoured either would change `busy` timing or the results of the following run.

// File: rtl/scan_time_calc.sv
module scan_time_calc #(
  parameter int N_SIB   = 3,
  parameter int LEN_W   = 16,
  parameter int PAT_W   = 16,
  parameter int CNT_W   = 32,
  parameter int CUC_LEN = 5,
  localparam int IDX_W  = (N_SIB > 1) ? $clog2(N_SIB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [PAT_W-1:0] cfg_pat,
  input  logic             start,
  input  logic             seq_mode,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] total_cycles,
  output logic [CNT_W-1:0] sib_cycles,
  output logic [CNT_W-1:0] cuc_cycles
);
  localparam int LEFT_W = PAT_W + 1;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [LEN_W-1:0]  len_q  [N_SIB];
  logic [PAT_W-1:0]  pat_q  [N_SIB];
  logic [LEFT_W-1:0] left_q [N_SIB];
  logic              busy_q, done_q, mode_q, any_q;
  logic [IDX_W-1:0]  idx_q, cur_q;
  logic [CNT_W-1:0]  tot_q, sib_q, cuc_q;

  logic              open_w, last_w, any_nx, cur_done;
  logic [LEFT_W-1:0] left_nx;
  logic [CNT_W:0]    step_w;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [CNT_W:0] b);
    logic [CNT_W+1:0] s;
    s = {2'b00, a} + {1'b0, b};
    return (s > {2'b00, MAXV}) ? MAXV : s[CNT_W-1:0];
  endfunction

  assign last_w  = (idx_q == IDX_W'(N_SIB - 1));
  assign open_w  = busy_q && (left_q[idx_q] != '0) && (!mode_q || idx_q == cur_q);
  assign left_nx = open_w ? left_q[idx_q] - LEFT_W'(1) : left_q[idx_q];
  assign any_nx  = any_q || (left_nx != '0);
  assign cur_done = (cur_q == idx_q) ? (left_nx == '0) : (left_q[cur_q] == '0);
  assign step_w  = (CNT_W+1)'(open_w ? len_q[idx_q] : '0) + (CNT_W+1)'(1)
                 + (last_w ? (CNT_W+1)'(CUC_LEN) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
      any_q  <= 1'b0;
      idx_q  <= '0;
      cur_q  <= '0;
      tot_q  <= '0;
      sib_q  <= '0;
      cuc_q  <= '0;
      for (int i = 0; i < N_SIB; i++) begin
        len_q[i]  <= '0;
        pat_q[i]  <= '0;
        left_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cfg_we) begin
          for (int i = 0; i < N_SIB; i++) begin
            if (cfg_idx == IDX_W'(i)) begin
              len_q[i] <= cfg_len;
              pat_q[i] <= cfg_pat;
            end
          end
        end
        if (start) begin
          busy_q <= 1'b1;
          mode_q <= seq_mode;
          any_q  <= 1'b0;
          idx_q  <= '0;
          cur_q  <= '0;
          tot_q  <= sat_add('0, (CNT_W+1)'(N_SIB + CUC_LEN));
          sib_q  <= sat_add('0, (CNT_W+1)'(N_SIB));
          cuc_q  <= sat_add('0, (CNT_W+1)'(CUC_LEN));
          for (int i = 0; i < N_SIB; i++)
            left_q[i] <= {1'b0, pat_q[i]} + LEFT_W'(1);
        end
      end else begin
        left_q[idx_q] <= left_nx;
        tot_q <= sat_add(tot_q, step_w);
        sib_q <= sat_add(sib_q, (CNT_W+1)'(1));
        if (last_w) begin
          cuc_q <= sat_add(cuc_q, (CNT_W+1)'(CUC_LEN));
          idx_q <= '0;
          any_q <= 1'b0;
          if (!any_nx) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else if (mode_q && cur_done) begin
            cur_q <= cur_q + IDX_W'(1);
          end
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          any_q <= any_nx;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign total_cycles = tot_q;
  assign sib_cycles   = sib_q;
  assign cuc_cycles   = cuc_q;
endmodule

// File: rtl/scan_time_calc_chk.sv
module scan_time_calc_chk #(
  parameter int CNT_W   = 32,
  parameter int CUC_LEN = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] total_cycles,
  input logic [CNT_W-1:0] sib_cycles,
  input logic [CNT_W-1:0] cuc_cycles
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(total_cycles) && $stable(sib_cycles) && $stable(cuc_cycles))); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (total_cycles >= $past(total_cycles) && sib_cycles >= $past(sib_cycles))); // R7
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R8
  AST_CUC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cuc_cycles == $past(cuc_cycles) ||
                              cuc_cycles == $past(cuc_cycles) + CNT_W'(CUC_LEN) ||
                              cuc_cycles == MAXV)); // R5
endmodule

bind scan_time_calc scan_time_calc_chk #(.CNT_W(CNT_W), .CUC_LEN(CUC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .total_cycles(total_cycles), .sib_cycles(sib_cycles), .cuc_cycles(cuc_cycles)
);

// File: tb/tb_scan_time_calc.sv
module tb_scan_time_calc;
  localparam int N = 3;
  localparam int LW = 12;
  localparam int PW = 8;
  localparam int CW = 16;
  localparam longint CMAX = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [PW-1:0] cfg_pat = '0;
  logic start = 1'b0;
  logic seq_mode = 1'b0;
  logic busy, done;
  logic [CW-1:0] total_cycles, sib_cycles, cuc_cycles;

  int errors = 0;
  int checks = 0;
  bit fin = 0;
  string tag = "R10";

  scan_time_calc #(.N_SIB(N), .LEN_W(LW), .PAT_W(PW), .CNT_W(CW), .CUC_LEN(5)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_len(cfg_len),
    .cfg_pat(cfg_pat), .start(start), .seq_mode(seq_mode), .busy(busy), .done(done),
    .total_cycles(total_cycles), .sib_cycles(sib_cycles), .cuc_cycles(cuc_cycles));

  always #2 clk = ~clk;

  longint mlen[N];
  longint mpat[N];
  bit mbusy = 0;
  bit mdone = 0;
  longint mleft = 0;
  longint etot = 0, esib = 0, ecuc = 0;

  task automatic calc(input bit mode);
    longint s = 0;
    longint t;
    for (int i = 0; i < N; i++) begin
      if (mode) s += mpat[i] + 1;
      else if (mpat[i] + 1 > s) s = mpat[i] + 1;
    end
    if (mode) begin
      t = N + 5;
      for (int i = 0; i < N; i++) t += (mlen[i] + N + 5) * (mpat[i] + 1);
    end else begin
      t = (N + 5) * (s + 1);
      for (int i = 0; i < N; i++) t += mlen[i] * (mpat[i] + 1);
    end
    etot = (t > CMAX) ? CMAX : t;
    esib = N * (s + 1);
    ecuc = 5 * (s + 1);
    mleft = N * s;
  endtask

  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      mbusy = 0; mdone = 0; etot = 0; esib = 0; ecuc = 0;
      for (int i = 0; i < N; i++) begin mlen[i] = 0; mpat[i] = 0; end
    end else begin
      was_busy = mbusy;
      mdone = 0;
      if (mbusy) begin
        mleft--;
        if (mleft == 0) begin mbusy = 0; mdone = 1; end
      end else if (start) begin
        calc(seq_mode);
        mbusy = 1;
      end
      if (cfg_we && !was_busy) begin
        mlen[cfg_idx] = cfg_len;
        mpat[cfg_idx] = cfg_pat;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !fin) begin
      check(busy == mbusy, "R3 busy", busy, mbusy);
      check(done == mdone, "R6 done", done, mdone);
      if (!mbusy) begin
        check(total_cycles == etot, {tag, " total"}, total_cycles, etot);
        check(sib_cycles == esib, {tag, " sib"}, sib_cycles, esib);
        check(cuc_cycles == ecuc, {tag, " cuc"}, cuc_cycles, ecuc);
      end
    end
  end

  task automatic wr(input int i, input int l, input int p);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(i); cfg_len = LW'(l); cfg_pat = PW'(p);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic launch(input bit mode);
    @(negedge clk);
    start = 1; seq_mode = mode;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_run();
    while (mbusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect3(input string req, input longint t, input longint s, input longint c);
    check(total_cycles == t, {req, " total"}, total_cycles, t);
    check(sib_cycles == s, {req, " sib"}, sib_cycles, s);
    check(cuc_cycles == c, {req, " cuc"}, cuc_cycles, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R10 flags", {busy, done}, 0);
    expect3("R10", 0, 0, 0);
    rst_n = 1;
    wr(0, 3, 5); wr(1, 5, 4); wr(2, 4, 10);

    tag = "R2";
    launch(0); finish_run();
    expect3("R1 R2 R5", 183, 36, 60);

    tag = "R4";
    launch(1); finish_run();
    expect3("R4 R5", 271, 69, 115);

    tag = "R8";
    launch(0);
    repeat (4) @(negedge clk);
    start = 1; seq_mode = 1;
    @(negedge clk);
    start = 0;
    finish_run();
    expect3("R8", 183, 36, 60);

    tag = "R9";
    launch(1);
    repeat (3) @(negedge clk);
    cfg_we = 1; cfg_idx = 0; cfg_len = 100; cfg_pat = 50;
    @(negedge clk);
    cfg_we = 0;
    finish_run();
    expect3("R9 run", 271, 69, 115);
    launch(1); finish_run();
    expect3("R9 after", 271, 69, 115);

    tag = "R3";
    wr(0, 1, 0); wr(1, 1, 0); wr(2, 1, 0);
    launch(0); finish_run();
    expect3("R3 conc", 19, 6, 10);
    launch(1); finish_run();
    expect3("R3 seq", 35, 12, 20);

    tag = "R3 mixed";
    wr(0, 7, 2); wr(1, 2, 0); wr(2, 9, 3);
    launch(0); finish_run();
    launch(1); finish_run();

    tag = "R7";
    wr(0, 4000, 20); wr(1, 4000, 20); wr(2, 4000, 20);
    launch(1); finish_run();
    expect3("R7 seq", 65535, 192, 320);
    launch(0); finish_run();
    expect3("R7 conc", 65535, 66, 110);

    repeat (5) @(negedge clk);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!fin) begin
      fin = 1;
      errors++; checks++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule